// File: doc/BRIEF.md
# Serial Fault-Status and Channel-Control Port

This block is the serial slave in front of a six-channel output controller. The host lowers chip select and clocks in a command byte. The low six bits of that byte turn the channels on, and the two top bits arm the on-state open-load checks. While the command comes in, the block shifts out a byte of sticky fault flags. The flags were captured at the moment chip select fell. Frames may be 8 or 16 bits long, or any whole number of bytes. In a 16-bit frame the second byte that comes back is the first byte the host sent, so the host can check that the command arrived intact.

A mode pin gives a fallback path. While the pin is high, the channels follow the parallel input pins and serial data out is released. The serial register still accepts a command, and that command takes over once the pin returns low. All serial inputs are oversampled in the system clock domain. The analog drivers, fault detection and retry timing are not part of this block.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset, `chan_on` and `ol_on_det` are 0, `ser_dout_en` is 0, and the first status byte read returns 0.
- R2: When chip select rises after a non-zero multiple of 8 clocks, the last 8 bits received become the command. Bits are received MSB first and sampled on the serial clock's rising edge. Bits 5..0 drive `chan_on[5:0]` while the mode pin is low. Bits 7..6 drive `ol_on_det[1:0]` in either mode.
- R3: A frame whose clock count is zero or not a multiple of 8 leaves the command unchanged and does not clear any fault flag.
- R4: The status byte is shifted out MSB first on `ser_dout`, and each bit is valid at the serial clock's rising edge. Bits 7..6 are 0, and bit i is the fault flag of channel i.
- R5: After the first 8 clocks, `ser_dout` returns the bits received 8 clocks earlier. The second byte of a 16-bit frame is therefore the first byte sent.
- R6: If `flt_raw[i]` is high for at least one clock while chip select is high, flag i reads 1 in every later status byte until a valid read completes.
- R7: The status byte is captured when chip select falls. A fault that starts during a transfer is absent from that transfer's byte and is reported in the next one.
- R8: A valid frame taken with the mode pin low clears each reported flag, unless its raw fault was present at some point during that transfer.
- R9: `ser_dout_en` is 1 only while chip select is low and the mode pin is low. `ser_dout` is 0 whenever `ser_dout_en` is 0.
- R10: While the mode pin is high, `chan_on[i]` follows `pin_in[i]`. A command received in this mode is stored and drives the channels once the pin returns low.
- R11: A frame taken while the mode pin is high clears no fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data from the host |
| pin_mode | input | 1 | High selects parallel-pin control and releases serial out |
| pin_in | input | 6 | Parallel channel inputs used while `pin_mode` is high |
| flt_raw | input | 6 | Per-channel raw fault flags from the detectors |
| ser_dout | output | 1 | Serial data to the host |
| ser_dout_en | output | 1 | Output enable for the external tri-state driver of `ser_dout` |
| chan_on | output | 6 | Channel-on commands |
| ol_on_det | output | 2 | Enables for on-state open-load detection |

## Verification
A wrong sticky flag or pending register shows up in the next status byte. The host sees it one full frame after the fault pulse, or two frames later when the fault arrived mid-transfer. A bit counter that is off by one does not corrupt the data. Instead, a valid frame fails to update `chan_on`, or a short frame updates it, within four system clocks after chip select rises. A wrong mode path shows within one clock of a `pin_in` change, and a wrong output enable shows on the first bit of the frame.

// File: rtl/spi_fo_pkg.sv
package spi_fo_pkg;

  // Edge events seen on the oversampled serial pins.
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
  } spi_ev_t;

  // Frame is valid when at least one whole byte arrived and no partial byte remains.
  function automatic logic frame_done(logic seen_byte, int unsigned bit_idx);
    return seen_byte && (bit_idx == 0);
  endfunction

  // Bit index within a byte, wrapping at the byte width.
  function automatic int unsigned next_idx(int unsigned bit_idx, int unsigned byte_w);
    return (bit_idx == byte_w - 1) ? 0 : bit_idx + 1;
  endfunction

  // Sticky flag update when chip select returns high.
  function automatic logic flag_on_close(logic cur, logic pend, logic raw, logic cleared);
    return cleared ? (pend | raw) : (cur | pend | raw);
  endfunction

endpackage

// File: rtl/spi_fo_sync.sv
module spi_fo_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fo_shift.sv
module spi_fo_shift
  import spi_fo_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_ev_t           ev,
  input  logic              cs_low,
  input  logic              din,
  input  logic [BYTE_W-1:0] load_val,
  output logic              msb,
  output logic [BYTE_W-1:0] word,
  output logic              frame_ok
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  idx_q;
  logic              seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else if (ev.cs_fall) begin
      sh_q   <= load_val;
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else if (cs_low && ev.sclk_rise) begin
      sh_q  <= {sh_q[BYTE_W-2:0], din};
      idx_q <= CNT_W'(next_idx(int'(idx_q), BYTE_W));
      if (int'(idx_q) == BYTE_W - 1) seen_q <= 1'b1;
    end
  end

  assign msb      = sh_q[BYTE_W-1];
  assign word     = sh_q;
  assign frame_ok = ev.cs_rise && frame_done(seen_q, int'(idx_q));
endmodule

// File: rtl/spi_fo_faults.sv
module spi_fo_faults
  import spi_fo_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_low,
  input  logic           cs_rise,
  input  logic           clear_ok,
  input  logic [NCH-1:0] raw,
  output logic [NCH-1:0] sticky
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic flag_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (cs_rise) begin
        flag_q <= flag_on_close(flag_q, pend_q, raw[g], clear_ok);
        pend_q <= 1'b0;
      end else if (cs_low) begin
        pend_q <= pend_q | raw[g];
      end else begin
        flag_q <= flag_q | raw[g];
      end
    end

    assign sticky[g] = flag_q;
  end
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
  import spi_fo_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CFG_BITS = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_cs_n,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                pin_mode,
  input  logic [NCH-1:0]      pin_in,
  input  logic [NCH-1:0]      flt_raw,
  output logic                ser_dout,
  output logic                ser_dout_en,
  output logic [NCH-1:0]      chan_on,
  output logic [CFG_BITS-1:0] ol_on_det
);
  localparam int unsigned BYTE_W = NCH + CFG_BITS;
  localparam int unsigned CNT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  // Oversampled serial pins: {cs_n, sclk, din, mode}
  logic [3:0] sync_q;
  spi_fo_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_cs_n, ser_clk, ser_din, pin_mode}),
    .q(sync_q)
  );

  logic cs_s, sclk_s, din_s, mode_s;
  assign {cs_s, sclk_s, din_s, mode_s} = sync_q;

  logic cs_d, sclk_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  // Named events for the checker
  logic cs_fall_ev, cs_rise_ev, sclk_rise_ev, cs_low;
  assign cs_fall_ev   = cs_d & ~cs_s;
  assign cs_rise_ev   = ~cs_d & cs_s;
  assign sclk_rise_ev = ~sclk_d & sclk_s;
  assign cs_low       = ~cs_s;

  spi_ev_t ev;
  assign ev = '{cs_fall: cs_fall_ev, cs_rise: cs_rise_ev, sclk_rise: sclk_rise_ev};

  logic [NCH-1:0]    sticky;
  logic [BYTE_W-1:0] rx_word;
  logic              sh_msb, frame_ok, clear_ok;

  spi_fo_shift #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cs_low(cs_low), .din(din_s),
    .load_val({{CFG_BITS{1'b0}}, sticky}),
    .msb(sh_msb), .word(rx_word), .frame_ok(frame_ok)
  );

  assign clear_ok = frame_ok & ~mode_s;

  spi_fo_faults #(.NCH(NCH)) u_faults (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise_ev),
    .clear_ok(clear_ok), .raw(flt_raw), .sticky(sticky)
  );

  logic [BYTE_W-1:0] cmd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      chan_on <= '0;
    end else begin
      if (frame_ok) cmd_q <= rx_word;
      chan_on <= mode_s ? pin_in : cmd_q[NCH-1:0];
    end
  end

  assign ol_on_det   = cmd_q[BYTE_W-1:NCH];
  assign ser_dout_en = cs_low & ~mode_s;
  assign ser_dout    = ser_dout_en & sh_msb;
endmodule

// File: rtl/spi_fault_ctrl_chk.sv
module spi_fault_ctrl_chk #(
  parameter int unsigned NCH = 6,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_hi,
  input logic              cs_rise_ev,
  input logic              mode_s,
  input logic [NCH-1:0]    pin_in,
  input logic [NCH-1:0]    chan_on,
  input logic [NCH-1:0]    flt_raw,
  input logic [NCH-1:0]    sticky,
  input logic [BYTE_W-1:0] cmd_q
);
  // R6: a flag never drops except right after chip select closes
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_rise_ev) |-> ((sticky & $past(sticky)) == $past(sticky)));

  // R6: a raw fault seen with chip select high is recorded the next cycle
  assert_fault_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> ((sticky & $past(flt_raw)) == $past(flt_raw)));

  // R7: flags are frozen while a transfer is open
  assert_frozen_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && $past(!cs_hi)) |-> $stable(sticky));

  // R2: the command only moves at the close of a frame
  assert_cmd_at_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_rise_ev) |-> $stable(cmd_q));

  // R10: in pin mode the channels follow the parallel inputs
  assert_pin_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_s) |-> (chan_on == $past(pin_in)));
endmodule

bind spi_fault_ctrl spi_fault_ctrl_chk #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .cs_rise_ev(cs_rise_ev),
  .mode_s(mode_s), .pin_in(pin_in), .chan_on(chan_on), .flt_raw(flt_raw),
  .sticky(sticky), .cmd_q(cmd_q)
);

// File: tb/tb_spi_fault_ctrl.sv
module tb_spi_fault_ctrl;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, pin_mode = 1'b0;
  logic [5:0] pin_in = '0, flt_raw = '0, raw_base = '0;
  logic ser_dout, ser_dout_en;
  logic [5:0] chan_on;
  logic [1:0] ol_on_det;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_fault_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .pin_mode(pin_mode), .pin_in(pin_in), .flt_raw(flt_raw),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .chan_on(chan_on),
    .ol_on_det(ol_on_det)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] p);
    flt_raw = raw_base | p;
    repeat (2) @(negedge clk);
    flt_raw = raw_base;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] data, input int n, input logic [5:0] inj,
                      output logic [23:0] rx, output logic oe_any);
    rx = '0;
    oe_any = 1'b0;
    @(negedge clk);
    ser_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = data[i];
      if (i == 3 && inj != 0) begin
        flt_raw = raw_base | inj;
        repeat (2) @(negedge clk);
        flt_raw = raw_base;
        repeat (H - 2) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
      rx = {rx[22:0], ser_dout};
      oe_any = oe_any | ser_dout_en;
      ser_clk = 1'b1;
      repeat (H) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (H) @(negedge clk);
    ser_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] cmd_of(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [23:0] rx;
    logic oe;
    logic [7:0] c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "chan_on", 32'(chan_on), 0);
    chk("R1", "ol_on_det", 32'(ol_on_det), 0);
    chk("R1", "ser_dout_en", 32'(ser_dout_en), 0);
    xfer(24'h00, 8, 6'h0, rx, oe);
    chk("R1", "first status", 32'(rx[7:0]), 0);

    // Sweep all fault patterns with varied commands (R2 R4 R6 R8 R9)
    for (int i = 0; i < 64; i++) begin
      c = cmd_of(i);
      pulse(6'(i));
      xfer({16'h0, c}, 8, 6'h0, rx, oe);
      chk("R4", "status byte", 32'(rx[7:0]), 32'({2'b00, 6'(i)}));
      chk("R2", "chan_on", 32'(chan_on), 32'(c[5:0]));
      chk("R2", "ol_on_det", 32'(ol_on_det), 32'(c[7:6]));
      if (i == 0) chk("R9", "oe during frame", 32'(oe), 1);
      xfer({16'h0, c}, 8, 6'h0, rx, oe);
      chk("R8", "cleared after read", 32'(rx[7:0]), 0);
    end

    // R5 16-bit echo, and 24-bit frame
    pulse(6'h2A);
    xfer({8'h0, 8'hA5, 8'hA5}, 16, 6'h0, rx, oe);
    chk("R4", "16b status", 32'(rx[15:8]), 32'h2A);
    chk("R5", "16b echo", 32'(rx[7:0]), 32'hA5);
    chk("R2", "16b chan_on", 32'(chan_on), 32'h25);
    chk("R2", "16b ol_on_det", 32'(ol_on_det), 32'h2);
    xfer({8'h81, 8'h42, 8'h1B}, 24, 6'h0, rx, oe);
    chk("R5", "24b echo", 32'(rx), 32'h008142);
    chk("R2", "24b last byte", 32'(chan_on), 32'h1B);
    chk("R2", "24b ol_on_det", 32'(ol_on_det), 0);

    // R3 partial frames
    pulse(6'h11);
    xfer(24'h1F, 5, 6'h0, rx, oe);
    chk("R3", "5 clocks chan_on", 32'(chan_on), 32'h1B);
    xfer(24'hFFF, 12, 6'h0, rx, oe);
    chk("R3", "12 clocks chan_on", 32'(chan_on), 32'h1B);
    chk("R3", "12 clocks ol_on_det", 32'(ol_on_det), 0);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R3", "flags kept", 32'(rx[7:0]), 32'h11);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R8", "cleared", 32'(rx[7:0]), 0);

    // R7 fault arriving mid transfer
    xfer(24'h1B, 8, 6'h04, rx, oe);
    chk("R7", "not in current byte", 32'(rx[7:0]), 0);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R7", "in next byte", 32'(rx[7:0]), 32'h04);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R8", "cleared after R7", 32'(rx[7:0]), 0);

    // R8 persistent fault
    raw_base = 6'h20;
    flt_raw = raw_base;
    repeat (2) @(negedge clk);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R8", "held read1", 32'(rx[7:0]), 32'h20);
    raw_base = 6'h00;
    flt_raw = raw_base;
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R8", "held read2", 32'(rx[7:0]), 32'h20);
    xfer(24'h1B, 8, 6'h0, rx, oe);
    chk("R8", "released", 32'(rx[7:0]), 0);

    // R10 R9 R11 pin mode
    xfer(24'h3C, 8, 6'h0, rx, oe);
    pin_mode = 1'b1;
    repeat (8) @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      pin_in = 6'(p);
      repeat (2) @(negedge clk);
      chk("R10", "chan_on follows pins", 32'(chan_on), 32'(p));
    end
    pin_in = 6'h15;
    pulse(6'h08);
    xfer(24'hC7, 8, 6'h0, rx, oe);
    chk("R9", "oe in pin mode", 32'(oe), 0);
    chk("R9", "dout in pin mode", 32'(rx[7:0]), 0);
    chk("R10", "pins still rule", 32'(chan_on), 32'h15);
    chk("R10", "ol_on_det from stored cmd", 32'(ol_on_det), 32'h3);
    pin_mode = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10", "stored cmd applied", 32'(chan_on), 32'h07);
    xfer(24'hC7, 8, 6'h0, rx, oe);
    chk("R11", "not cleared in pin mode", 32'(rx[7:0]), 32'h08);
    xfer(24'hC7, 8, 6'h0, rx, oe);
    chk("R8", "cleared in serial mode", 32'(rx[7:0]), 0);
    chk("R9", "oe idle", 32'(ser_dout_en), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule